// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital timing control for a successive-approximation converter. It divides the system clock into an ADC clock enable (`adc_tick`) and derives a half-rate phase (`adc_phase`) that toggles on every tick. A conversion can be requested in two ways: by a one-cycle software start pulse, or by an external trigger when the trigger gate is set. The block counts ADC clock cycles for each conversion and opens a sample window at the start of each conversion. At the end it raises a sticky done flag and a one-cycle result strobe. The conversion result is an input from the analog side and is captured at the completing tick.

Conversion length depends on how the request arrives:
- A software start waits for the next ADC tick. It then lasts 13 or 14 ADC cycles, depending on the phase at that tick.
- An external trigger resets the divider first, so the conversion always begins on a low phase.
- In free-running mode each completion immediately starts the next conversion at the longer 14-cycle length.

Differential-gain operation needs a settled gain stage. If differential gain is on, the first conversion after enabling is extended. A triggered conversion that was not preceded by an enable toggle is marked invalid.

The result strobe is a plain one-cycle pulse with no back-pressure. The analog timing cannot stall, so the consumer must take `res_data` in the cycle `res_valid` is high.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A software start (`start_wr` high for one clock while idle and enabled) begins the conversion on the first `adc_tick` after the write. If `adc_phase` is 0 at that tick, the conversion lasts 13 ADC ticks, counted after the beginning tick up to and including the completing tick.
- R2: If `adc_phase` is 1 at the beginning tick of a software-started conversion, the conversion lasts 14 ADC ticks.
- R3: With `free_run` set, each completion starts the next conversion in the same cycle: `busy` stays 1 and the next completion follows exactly 14 ADC ticks later. When `free_run` is 0 at a completion, `busy` falls.
- R4: An accepted trigger (`trig_in` high with `trig_en` set, while idle) resets the divider. The first tick comes `DIV` clocks after the accepting edge, with `adc_phase` 0, and the conversion lasts 13 ADC ticks.
- R5: A trigger-started conversion with `diff_gain` set, and no enable toggle since the previous conversion began, completes with `res_inv` = 1. Software-started and free-running conversions give `res_inv` = 0.
- R6: The first conversion begun after `enable` rises (or after reset) lasts 25 ADC ticks when `diff_gain` is 1, and completes with `res_inv` = 0.
- R7: Software starts and triggers that arrive while `busy` is 1 are ignored: they neither start an extra conversion nor produce an extra `res_valid`.
- R8: Dropping `enable` aborts any conversion. From the next clock, `busy`, `sample_win` and `adc_phase` are 0, and no `res_valid` or `done_flag` is produced for the aborted conversion.
- R9: `done_flag` is set at each completion and stays set until `done_clr` is high. If a completion and `done_clr` occur in the same cycle, the set wins.
- R10: `res_valid` is high for exactly one clock after each completing tick. `res_data` then holds `result_in` as sampled at that tick.
- R11: `sample_win` is high for the first `SAMPLE_CYC` ADC cycles of each conversion, which is `SAMPLE_CYC*DIV` system clocks.
- R12: After reset, `busy`, `sample_win`, `done_flag`, `res_valid`, `res_inv`, `adc_tick` and `adc_phase` are all 0. A reset during a conversion returns `busy` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Converter enable; low aborts and re-arms the settling logic |
| free_run | input | 1 | Restart a 14-cycle conversion at every completion |
| trig_en | input | 1 | Gate for the external trigger |
| diff_gain | input | 1 | Differential-gain channel selected |
| start_wr | input | 1 | One-cycle software start request |
| trig_in | input | 1 | External trigger pulse |
| done_clr | input | 1 | Write-one-to-clear for `done_flag` |
| result_in | input | RES_W | Conversion value from the analog side |
| busy | output | 1 | Conversion requested or running (start readback) |
| sample_win | output | 1 | Sample-and-hold window |
| adc_tick | output | 1 | ADC clock enable, one system clock wide |
| adc_phase | output | 1 | Half-rate ADC clock phase |
| done_flag | output | 1 | Sticky completion flag |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | RES_W | Captured result |
| res_inv | output | 1 | Result marked invalid (unsettled gain stage) |

## Verification
Each conversion result is due one system clock after the edge that carries its completing tick. That tick is the length-th tick after the beginning tick. The beginning tick is the first tick after the accepting edge; for a trigger it comes exactly `DIV` clocks after that edge. The bench samples every output at the falling edge, where registers have settled. It measures a conversion by counting ticks seen while `busy` is high, from the write until `res_valid`: the count equals the length plus the beginning tick. For software starts, the bench waits for a tick of the opposite phase before writing, so the phase at the beginning tick, and hence the expected length, is known in advance.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_CONV = 2'd2
  } seq_state_e;

endpackage

// File: rtl/adc_seq_presc.sv
module adc_seq_presc #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick,
  output logic phase
);

  localparam int PC_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(DIV - 1);

  logic [PC_W-1:0] pc_q;
  logic            phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      phase_q <= 1'b0;
    end else if (clr || !run) begin
      pc_q    <= '0;
      phase_q <= 1'b0;
    end else if (pc_q == PC_LAST) begin
      pc_q    <= '0;
      phase_q <= ~phase_q;
    end else begin
      pc_q <= pc_q + 1'b1;
    end
  end

  assign tick  = run && !clr && (pc_q == PC_LAST);
  assign phase = phase_q;

  AST_PRESC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pc_q == '0) && !phase_q); // R4

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R10

endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
  import adc_seq_pkg::*;
#(
  parameter int NORM_LEN   = 13,
  parameter int SYNC_LEN   = 14,
  parameter int EXT_LEN    = 25,
  parameter int SAMPLE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tick,
  input  logic phase,
  input  logic sw_req,
  input  logic trig_req,
  input  logic free_run,
  input  logic diff_gain,
  output logic busy,
  output logic sample_win,
  output logic presc_clr,
  output logic done_evt,
  output logic done_inv
);

  localparam int CNT_W = $clog2(EXT_LEN + 1);
  localparam logic [CNT_W-1:0] L_NORM = CNT_W'(NORM_LEN);
  localparam logic [CNT_W-1:0] L_SYNC = CNT_W'(SYNC_LEN);
  localparam logic [CNT_W-1:0] L_EXT  = CNT_W'(EXT_LEN);
  localparam logic [CNT_W-1:0] L_SAMP = CNT_W'(SAMPLE_CYC);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] begin_len;
  logic             inv_q;
  logic             auto_q;
  logic             fresh_q;
  logic             accept;
  logic             last;

  assign accept    = enable && (state_q == SEQ_IDLE) && (sw_req || trig_req);
  assign presc_clr = !enable || (accept && trig_req);
  assign last      = (state_q == SEQ_CONV) && tick && (cnt_q == len_q - 1'b1);
  assign done_evt  = enable && last;
  assign done_inv  = inv_q;
  assign busy      = (state_q != SEQ_IDLE);
  assign sample_win = (state_q == SEQ_CONV) && (cnt_q < L_SAMP);

  always_comb begin
    if (diff_gain && fresh_q) begin
      begin_len = L_EXT;
    end else if (phase) begin
      begin_len = L_SYNC;
    end else begin
      begin_len = L_NORM;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      len_q   <= L_NORM;
      inv_q   <= 1'b0;
      auto_q  <= 1'b0;
      fresh_q <= 1'b1;
    end else if (!enable) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      inv_q   <= 1'b0;
      auto_q  <= 1'b0;
      fresh_q <= 1'b1;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (accept) begin
            state_q <= SEQ_WAIT;
            auto_q  <= trig_req;
          end
        end
        SEQ_WAIT: begin
          if (tick) begin
            state_q <= SEQ_CONV;
            cnt_q   <= '0;
            len_q   <= begin_len;
            inv_q   <= auto_q && diff_gain && !fresh_q;
            fresh_q <= 1'b0;
          end
        end
        SEQ_CONV: begin
          if (tick) begin
            if (last) begin
              cnt_q <= '0;
              if (free_run) begin
                len_q <= L_SYNC;
                inv_q <= 1'b0;
              end else begin
                state_q <= SEQ_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  AST_RESTART_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && free_run |=> busy && (len_q == L_SYNC)); // R3

  AST_AUTO_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_WAIT) && tick && auto_q |-> !phase); // R4

  AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_CONV) && enable && !last |=> (state_q == SEQ_CONV)); // R7

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy && !sample_win); // R8

endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_evt,
  input  logic             done_inv,
  input  logic             done_clr,
  input  logic [RES_W-1:0] result_in,
  output logic             done_flag,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data,
  output logic             res_inv
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_inv   <= 1'b0;
    end else begin
      res_valid <= done_evt;
      if (done_evt) begin
        done_flag <= 1'b1;
        res_data  <= result_in;
        res_inv   <= done_inv;
      end else if (done_clr) begin
        done_flag <= 1'b0;
      end
    end
  end

  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R10

  AST_DONE_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> res_valid); // R9

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_flag && !done_clr |=> done_flag); // R9

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int DIV        = 4,
  parameter int RES_W      = 10,
  parameter int NORM_LEN   = 13,
  parameter int SYNC_LEN   = 14,
  parameter int EXT_LEN    = 25,
  parameter int SAMPLE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             free_run,
  input  logic             trig_en,
  input  logic             diff_gain,
  input  logic             start_wr,
  input  logic             trig_in,
  input  logic             done_clr,
  input  logic [RES_W-1:0] result_in,
  output logic             busy,
  output logic             sample_win,
  output logic             adc_tick,
  output logic             adc_phase,
  output logic             done_flag,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data,
  output logic             res_inv
);

  logic presc_clr;
  logic done_evt;
  logic done_inv;

  adc_seq_presc #(.DIV(DIV)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (enable),
    .clr   (presc_clr),
    .tick  (adc_tick),
    .phase (adc_phase)
  );

  adc_seq_core #(
    .NORM_LEN   (NORM_LEN),
    .SYNC_LEN   (SYNC_LEN),
    .EXT_LEN    (EXT_LEN),
    .SAMPLE_CYC (SAMPLE_CYC)
  ) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .tick       (adc_tick),
    .phase      (adc_phase),
    .sw_req     (start_wr),
    .trig_req   (trig_in && trig_en),
    .free_run   (free_run),
    .diff_gain  (diff_gain),
    .busy       (busy),
    .sample_win (sample_win),
    .presc_clr  (presc_clr),
    .done_evt   (done_evt),
    .done_inv   (done_inv)
  );

  adc_seq_capture #(.RES_W(RES_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_evt  (done_evt),
    .done_inv  (done_inv),
    .done_clr  (done_clr),
    .result_in (result_in),
    .done_flag (done_flag),
    .res_valid (res_valid),
    .res_data  (res_data),
    .res_inv   (res_inv)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> !busy && !done_flag); // R12

endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;

  localparam int DIV   = 4;
  localparam int RES_W = 10;
  localparam int SAMP  = 2;

  logic clk = 1'b0;
  logic rst_n, enable, free_run, trig_en, diff_gain, start_wr, trig_in, done_clr;
  logic [RES_W-1:0] result_in;
  logic busy, sample_win, adc_tick, adc_phase, done_flag, res_valid, res_inv;
  logic [RES_W-1:0] res_data;

  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  adc_seq_ctrl #(.DIV(DIV), .RES_W(RES_W), .SAMPLE_CYC(SAMP)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .free_run(free_run), .trig_en(trig_en),
    .diff_gain(diff_gain), .start_wr(start_wr), .trig_in(trig_in), .done_clr(done_clr),
    .result_in(result_in), .busy(busy), .sample_win(sample_win), .adc_tick(adc_tick),
    .adc_phase(adc_phase), .done_flag(done_flag), .res_valid(res_valid),
    .res_data(res_data), .res_inv(res_inv)
  );

  typedef struct packed {
    logic             is_auto;
    logic             diff;
    logic             ph;
    logic [RES_W-1:0] data;
    logic [4:0]       len;
    logic             inv;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 1'b0, 10'h155, 5'd13, 1'b0},
    '{1'b0, 1'b0, 1'b1, 10'h2AA, 5'd14, 1'b0},
    '{1'b1, 1'b0, 1'b0, 10'h3FF, 5'd13, 1'b0},
    '{1'b1, 1'b1, 1'b0, 10'h001, 5'd13, 1'b1},
    '{1'b0, 1'b1, 1'b1, 10'h0F0, 5'd14, 1'b0},
    '{1'b0, 1'b0, 1'b0, 10'h30C, 5'd13, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
  endtask

  // Walks negedges until res_valid; counts ticks seen while busy, sample clocks.
  task automatic measure(output int ticks, output int samp, output int first_at,
                         output int first_ph, output logic [RES_W-1:0] d,
                         output logic inv, output int ok);
    ticks = 0; samp = 0; first_at = -1; first_ph = -1; ok = 0; d = '0; inv = 1'b0;
    for (int i = 0; i < 600; i++) begin
      if (res_valid) begin
        d = res_data; inv = res_inv; ok = 1;
        break;
      end
      if (busy && adc_tick) begin
        if (first_at < 0) begin
          first_at = i;
          first_ph = int'(adc_phase);
        end
        ticks++;
      end
      if (sample_win) samp++;
      @(negedge clk);
    end
  endtask

  task automatic gap(output int t);
    t = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (res_valid) break;
      if (adc_tick) t++;
    end
  endtask

  task automatic sw_start();
    @(negedge clk); start_wr = 1'b1;
    @(negedge clk); start_wr = 1'b0;
  endtask

  task automatic trig_pulse();
    @(negedge clk); trig_in = 1'b1;
    @(negedge clk); trig_in = 1'b0;
  endtask

  task automatic clear_done();
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int ticks, samp, fat, fph, ok, t, nv;
    logic [RES_W-1:0] d;
    logic inv;
    string rq;

    rst_n = 1'b0; enable = 1'b0; free_run = 1'b0; trig_en = 1'b1; diff_gain = 1'b0;
    start_wr = 1'b0; trig_in = 1'b0; done_clr = 1'b0; result_in = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 busy", int'(busy), 0);
    chk("R12 done_flag", int'(done_flag), 0);
    chk("R12 res_valid", int'(res_valid), 0);
    chk("R12 quiet", int'({sample_win, adc_tick, adc_phase, res_inv}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);

    // Table walk: R1 R2 R4 R5 R10 R11 R9
    foreach (VECS[k]) begin
      diff_gain = VECS[k].diff;
      result_in = VECS[k].data;
      if (VECS[k].is_auto) begin
        trig_pulse();
      end else begin
        do @(negedge clk); while (!(adc_tick && (adc_phase != VECS[k].ph)));
        start_wr = 1'b1;
        @(negedge clk); start_wr = 1'b0;
      end
      measure(ticks, samp, fat, fph, d, inv, ok);
      rq = VECS[k].is_auto ? (VECS[k].inv ? "R5" : "R4") : (VECS[k].ph ? "R2" : "R1");
      chk({rq, " completed"}, ok, 1);
      chk({rq, " length"}, ticks - 1, int'(VECS[k].len));
      chk("R5 invalid mark", int'(inv), int'(VECS[k].inv));
      chk("R10 data", int'(d), int'(VECS[k].data));
      chk("R11 sample clocks", samp, SAMP * DIV);
      chk("R9 done set", int'(done_flag), 1);
      if (VECS[k].is_auto) begin
        chk("R4 first tick delay", fat, DIV - 1);
        chk("R4 phase low", fph, 0);
      end
      @(negedge clk);
      chk("R10 strobe one cycle", int'(res_valid), 0);
      clear_done();
      chk("R9 cleared", int'(done_flag), 0);
    end

    // R6 extended first conversion after enable toggle, then R5 invalid
    @(negedge clk); enable = 1'b0;
    @(negedge clk); enable = 1'b1; diff_gain = 1'b1; result_in = 10'h123;
    trig_pulse();
    measure(ticks, samp, fat, fph, d, inv, ok);
    chk("R6 length", ticks - 1, 25);
    chk("R6 valid", int'(inv), 0);
    clear_done();
    trig_pulse();
    measure(ticks, samp, fat, fph, d, inv, ok);
    chk("R5 length", ticks - 1, 13);
    chk("R5 invalid", int'(inv), 1);
    clear_done();
    diff_gain = 1'b0;

    // R3 free running
    free_run = 1'b1;
    sw_start();
    measure(ticks, samp, fat, fph, d, inv, ok);
    chk("R3 first done", ok, 1);
    gap(t);
    chk("R3 restart length", t, 14);
    chk("R3 busy held", int'(busy), 1);
    gap(t);
    chk("R3 restart length 2", t, 14);
    free_run = 1'b0;
    gap(t);
    chk("R3 last length", t, 14);
    @(negedge clk);
    chk("R3 stops", int'(busy), 0);
    clear_done();

    // R7 starts while busy ignored
    sw_start();
    repeat (10) @(negedge clk);
    start_wr = 1'b1; @(negedge clk); start_wr = 1'b0;
    repeat (5) @(negedge clk);
    trig_in = 1'b1; @(negedge clk); trig_in = 1'b0;
    measure(ticks, samp, fat, fph, d, inv, ok);
    chk("R7 first completes", ok, 1);
    nv = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (res_valid) nv++;
    end
    chk("R7 no extra result", nv, 0);
    chk("R7 idle after", int'(busy), 0);
    clear_done();

    // R8 abort
    sw_start();
    repeat (30) @(negedge clk);
    chk("R8 busy before abort", int'(busy), 1);
    enable = 1'b0;
    @(negedge clk);
    chk("R8 busy cleared", int'(busy), 0);
    chk("R8 phase reset", int'(adc_phase), 0);
    chk("R8 sample closed", int'(sample_win), 0);
    repeat (10) @(negedge clk);
    enable = 1'b1;
    nv = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (res_valid) nv++;
    end
    chk("R8 no strobe", nv, 0);
    chk("R8 no done", int'(done_flag), 0);

    // R9 set wins over clear in the same cycle
    done_clr = 1'b1;
    sw_start();
    measure(ticks, samp, fat, fph, d, inv, ok);
    chk("R9 set priority", int'(done_flag), 1);
    @(negedge clk);
    chk("R9 clear next", int'(done_flag), 0);
    done_clr = 1'b0;

    // R12 reset during a conversion
    sw_start();
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12 reset aborts", int'(busy), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    summary();
    $finish;
  end

endmodule